// File: doc/BRIEF.md
# Store Address Queue with Data Pairing

This block lets a memory-access pipeline issue a store as soon as its address is known, without waiting for the value to be written. The address goes into a small in-order queue. Store values come later, one word at a time, from the stream fed by the compute side. Each value is joined with the oldest waiting address, and the pair leaves as one memory write request. Stores therefore complete in the order their addresses were issued.

Each load address the pipeline is about to issue is compared against every pending store address in the queue. If any of them matches, the load is held. Once a hold has been raised, every load after it stays held, whatever its address, until the youngest store that matched at that moment has written to memory. This keeps a load from passing an older store to the same location.

An empty flag is provided. Other consumers of the store-value stream, for example a read that uses a value for address arithmetic, use it to wait until no store is waiting for data.

Top module: `store_pair_queue`

## Requirements
- R1: A store address is accepted on a cycle with `stAddrValid` and `stAddrReady` both high. `stAddrReady` is low while all DEPTH entries are in use, and an address offered then is dropped.
- R2: Every write request carries the oldest pending address on `wrAddr` and the present `stData` word on `wrData`. Writes leave in the same order as their addresses were accepted.
- R3: `wrValid` is high exactly when the queue holds an entry and `stDataValid` is high. An entry and its data word are consumed only on a cycle where `wrValid` and `wrReady` are both high. When `wrReady` is low, `stDataReady` is low and nothing is removed.
- R4: While the queue is empty, arriving store data is not taken: `stDataReady` and `wrValid` both stay low.
- R5: `queueEmpty` is high exactly when no store address is pending. Reads of the store-value stream for any purpose other than a store wait on this flag.
- R6: `ldHold` goes high in the same cycle as `ldAddrValid` when `ldAddr` equals the address of any pending entry, at any position in the queue.
- R7: With no hold in progress, a load whose address matches no pending entry is not held. This includes an address whose store has already been written to memory.
- R8: A hold starts when a matching load is presented across a clock edge. From then on, every load is held regardless of its address until the youngest entry that matched has been written. Loads are released in the cycle after that write is accepted.
- R9: After reset the queue is empty, `stAddrReady` is high, `wrValid` is low, and no load is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stAddrValid | input | 1 | A store address is offered |
| stAddr | input | ADDR_W | Store address being offered |
| stAddrReady | output | 1 | Queue has a free entry |
| stDataValid | input | 1 | A store data word is offered |
| stData | input | DATA_W | Store data word |
| stDataReady | output | 1 | The data word is consumed this cycle |
| ldAddrValid | input | 1 | A load address is presented for checking |
| ldAddr | input | ADDR_W | Load address to check |
| ldHold | output | 1 | The presented load must not issue |
| wrValid | output | 1 | A paired write request is presented |
| wrAddr | output | ADDR_W | Address of the write request |
| wrData | output | DATA_W | Data of the write request |
| wrReady | input | 1 | Memory accepts the write request |
| queueEmpty | output | 1 | No store address is pending |

## Verification
The bench fills the queue and then offers one more address. A design that let that address in would produce an extra write or overwrite an entry. The bench then compares load addresses against the oldest entry, the youngest entry and several near-miss values. A compare that skipped slots or stopped at the first match would give the wrong hold. Next it holds a load on a middle entry and switches to an unrelated address, and it stalls memory with `wrReady` low for one cycle. Release must come exactly one cycle after the matching store drains. A design that released on address alone, or that popped during the stall, would let the unrelated load through early or lose a write. It also offers data to an empty queue, and it pushes and pops in the same cycle. A design that got either wrong would produce a write with a stale address or miscount the number of pending entries.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // strobes the control side hands to the datapath each cycle
  typedef struct packed {
    logic push;   // store address enters at the tail
    logic pop;    // head entry leaves as a paired write
  } sqStrobe_t;
endpackage

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqStrobe_t         ctl,
  input  logic [ADDR_W-1:0] pushAddr,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic [ADDR_W-1:0] headAddr,
  output logic              matchAny,
  output logic [$clog2(DEPTH+1)-1:0] matchDepth
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DEPTH-1:0]  validVec;
  logic [PTR_W-1:0]  headPtr;
  logic [PTR_W-1:0]  tailPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (ctl.push) tailPtr <= nextPtr(tailPtr);
      if (ctl.pop)  headPtr <= nextPtr(headPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.push) addrMem[tailPtr] <= pushAddr;
  end

  // one occupancy bit per slot
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        validVec[g] <= 1'b0;
      else if (ctl.push && tailPtr == PTR_W'(g))
        validVec[g] <= 1'b1;
      else if (ctl.pop && headPtr == PTR_W'(g))
        validVec[g] <= 1'b0;
    end
  end

  assign headAddr = addrMem[headPtr];

  // associative compare; later (younger) hits overwrite earlier ones
  always_comb begin
    int s;
    matchDepth = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = int'(headPtr) + k;
      if (s >= DEPTH) s = s - DEPTH;
      if (validVec[s] && addrMem[s] == ldAddr) matchDepth = CNT_W'(k + 1);
    end
  end
  assign matchAny = (matchDepth != '0);

  AST_POP_HEAD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> validVec[headPtr]);  // R2
  AST_PUSH_SLOT_FREE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |-> !validVec[tailPtr]);  // R1
endmodule

// File: rtl/sq_control.sv
module sq_control
  import sq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      stAddrValid,
  input  logic      stDataValid,
  input  logic      wrReady,
  input  logic      ldAddrValid,
  input  logic      matchAny,
  input  logic [$clog2(DEPTH+1)-1:0] matchDepth,
  output sqStrobe_t ctl,
  output logic      stAddrReady,
  output logic      stDataReady,
  output logic      wrValid,
  output logic      queueEmpty,
  output logic      ldHold
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] holdBase;
  logic [CNT_W-1:0] holdNext;
  logic             holdLoad;

  assign queueEmpty  = (count == '0);
  assign stAddrReady = (count != CNT_W'(DEPTH));
  assign wrValid     = !queueEmpty && stDataValid;
  assign stDataReady = !queueEmpty && wrReady;
  assign ctl.push    = stAddrValid && stAddrReady;
  assign ctl.pop     = wrValid && wrReady;

  always_ff @(posedge clk) begin
    if (!rstN)
      count <= '0;
    else if (ctl.push && !ctl.pop)
      count <= count + CNT_W'(1);
    else if (!ctl.push && ctl.pop)
      count <= count - CNT_W'(1);
  end

  // hold window: number of pops until the youngest matching store is gone
  assign holdLoad = ldAddrValid && matchAny && (holdCnt == '0);

  always_comb begin
    holdBase = holdLoad ? matchDepth : holdCnt;
    holdNext = (ctl.pop && holdBase != '0) ? holdBase - CNT_W'(1) : holdBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdCnt <= '0;
    else       holdCnt <= holdNext;
  end

  assign ldHold = ldAddrValid && (matchAny || holdCnt != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));  // R1
  AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !ctl.pop) |=> count == $past(count) + CNT_W'(1));  // R1
  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    queueEmpty |-> (!wrValid && !stDataReady));  // R4
  AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ldAddrValid && matchAny) |-> ldHold);  // R6
  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ldAddrValid && holdCnt != '0) |-> ldHold);  // R8
  AST_HOLD_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (holdCnt != '0 && ctl.pop) |=> holdCnt == $past(holdCnt) - CNT_W'(1));  // R8
endmodule

// File: rtl/store_pair_queue.sv
module store_pair_queue
  import sq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stAddrValid,
  input  logic [ADDR_W-1:0] stAddr,
  output logic              stAddrReady,
  input  logic              stDataValid,
  input  logic [DATA_W-1:0] stData,
  output logic              stDataReady,
  input  logic              ldAddrValid,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              ldHold,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrReady,
  output logic              queueEmpty
);
  localparam int CNT_W = $clog2(DEPTH+1);

  sqStrobe_t        ctl;
  logic             matchAny;
  logic [CNT_W-1:0] matchDepth;

  sq_control #(.DEPTH(DEPTH)) uCtl (
    .clk(clk), .rstN(rstN),
    .stAddrValid(stAddrValid), .stDataValid(stDataValid), .wrReady(wrReady),
    .ldAddrValid(ldAddrValid), .matchAny(matchAny), .matchDepth(matchDepth),
    .ctl(ctl), .stAddrReady(stAddrReady), .stDataReady(stDataReady),
    .wrValid(wrValid), .queueEmpty(queueEmpty), .ldHold(ldHold)
  );

  sq_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .pushAddr(stAddr), .ldAddr(ldAddr),
    .headAddr(wrAddr), .matchAny(matchAny), .matchDepth(matchDepth)
  );

  assign wrData = stData;
endmodule

// File: tb/tb_store_pair_queue.sv
module tb_store_pair_queue;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  logic rstN;
  logic stAddrValid, stDataValid, ldAddrValid, wrReady;
  logic [ADDR_W-1:0] stAddr, ldAddr;
  logic [DATA_W-1:0] stData;
  logic stAddrReady, stDataReady, ldHold, wrValid, queueEmpty;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [ADDR_W-1:0] logA [16];
  logic [DATA_W-1:0] logD [16];

  typedef struct packed { logic [ADDR_W-1:0] a; logic h; } ldVec_t;
  // queue holds 0100,0200,0300,0400 when this table is walked
  localparam ldVec_t LD_TABLE [7] = '{
    '{16'h0100, 1'b1}, '{16'h0400, 1'b1}, '{16'h0250, 1'b0},
    '{16'h0000, 1'b0}, '{16'h0300, 1'b1}, '{16'h0401, 1'b0},
    '{16'h0200, 1'b1}};

  always #(CLK_PERIOD/2) clk = ~clk;

  store_pair_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN),
    .stAddrValid(stAddrValid), .stAddr(stAddr), .stAddrReady(stAddrReady),
    .stDataValid(stDataValid), .stData(stData), .stDataReady(stDataReady),
    .ldAddrValid(ldAddrValid), .ldAddr(ldAddr), .ldHold(ldHold),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady),
    .queueEmpty(queueEmpty));

  always @(posedge clk) begin
    if (rstN && wrValid && wrReady && wrCount < 16) begin
      logA[wrCount] <= wrAddr;
      logD[wrCount] <= wrData;
      wrCount <= wrCount + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    stAddrValid = 0; stDataValid = 0; wrReady = 0;
  endtask

  task automatic pushAddr(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    stAddrValid = 1; stAddr = a;
    @(posedge clk); #1 idle();
  endtask

  task automatic popData(input logic [DATA_W-1:0] d, input logic [ADDR_W-1:0] expA);
    @(negedge clk);
    stDataValid = 1; stData = d; wrReady = 1;
    #1;
    chk("R3 wrValid", 64'(wrValid), 64'd1);
    chk("R2 wrAddr", 64'(wrAddr), 64'(expA));
    chk("R2 wrData", 64'(wrData), 64'(d));
    @(posedge clk); #1 idle();
  endtask

  task automatic loadProbe(input logic [ADDR_W-1:0] a, input logic expH, input string req);
    @(negedge clk);
    ldAddrValid = 1; ldAddr = a;
    #1 chk(req, 64'(ldHold), 64'(expH));
    #1 ldAddrValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; idle(); ldAddrValid = 0; stAddr = '0; ldAddr = '0; stData = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R9 reset state
    #1;
    chk("R9 empty", 64'(queueEmpty), 64'd1);
    chk("R9 addr ready", 64'(stAddrReady), 64'd1);
    chk("R9 wrValid", 64'(wrValid), 64'd0);
    loadProbe(16'h0005, 1'b0, "R9 no hold");

    // R4 data offered to an empty queue
    @(negedge clk);
    stDataValid = 1; stData = 32'hDEAD0000; wrReady = 1;
    #1;
    chk("R4 data ready", 64'(stDataReady), 64'd0);
    chk("R4 wrValid", 64'(wrValid), 64'd0);
    @(posedge clk); #1 idle();

    // R1 fill to DEPTH entries
    pushAddr(16'h0100);
    #1 chk("R5 not empty", 64'(queueEmpty), 64'd0);
    pushAddr(16'h0200);
    pushAddr(16'h0300);
    pushAddr(16'h0400);
    #1 chk("R1 full not ready", 64'(stAddrReady), 64'd0);
    pushAddr(16'h0500);  // refused; must never reach memory

    // R6 / R7 associative compare table
    for (int i = 0; i < 7; i++)
      loadProbe(LD_TABLE[i].a, LD_TABLE[i].h, LD_TABLE[i].h ? "R6 match" : "R7 miss");

    // R8 sticky hold: load on 0200 crosses an edge, then an unrelated load
    @(negedge clk); ldAddrValid = 1; ldAddr = 16'h0200;
    @(posedge clk); #1 ldAddr = 16'h0999;
    #1 chk("R8 sticky", 64'(ldHold), 64'd1);
    popData(32'hA0000001, 16'h0100);
    #1 chk("R8 still held", 64'(ldHold), 64'd1);

    // R3 memory not ready: nothing consumed
    @(negedge clk);
    stDataValid = 1; stData = 32'hA0000002; wrReady = 0;
    #1;
    chk("R3 wrValid stalled", 64'(wrValid), 64'd1);
    chk("R3 data not ready", 64'(stDataReady), 64'd0);
    @(posedge clk); #1 idle();

    popData(32'hA0000002, 16'h0200);
    #1 chk("R8 released", 64'(ldHold), 64'd0);
    @(negedge clk); ldAddrValid = 0;
    loadProbe(16'h0200, 1'b0, "R7 drained addr");
    loadProbe(16'h0300, 1'b1, "R6 still pending");

    popData(32'hA0000003, 16'h0300);
    popData(32'hA0000004, 16'h0400);
    #1;
    chk("R5 empty after drain", 64'(queueEmpty), 64'd1);
    chk("R1 ready after drain", 64'(stAddrReady), 64'd1);

    // R2 push and pop in the same cycle
    pushAddr(16'h0AAA);
    @(negedge clk);
    stAddrValid = 1; stAddr = 16'h0BBB;
    stDataValid = 1; stData = 32'hB0000005; wrReady = 1;
    #1;
    chk("R2 simul addr", 64'(wrAddr), 64'h0AAA);
    @(posedge clk); #1 idle();
    #1 chk("R5 one left", 64'(queueEmpty), 64'd0);
    popData(32'hB0000006, 16'h0BBB);
    #1 chk("R5 empty end", 64'(queueEmpty), 64'd1);

    // R2 write log order and pairing; R1 refused address absent
    @(negedge clk);
    chk("R1 write count", 64'(wrCount), 64'd6);
    chk("R2 log0", {logA[0], logD[0]}, {16'h0100, 32'hA0000001});
    chk("R2 log1", {logA[1], logD[1]}, {16'h0200, 32'hA0000002});
    chk("R2 log2", {logA[2], logD[2]}, {16'h0300, 32'hA0000003});
    chk("R2 log3", {logA[3], logD[3]}, {16'h0400, 32'hA0000004});
    chk("R2 log4", {logA[4], logD[4]}, {16'h0AAA, 32'hB0000005});
    chk("R2 log5", {logA[5], logD[5]}, {16'h0BBB, 32'hB0000006});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule